// File: doc/BRIEF.md
# Circular Receive Buffer Writer

This block takes a stream of received bytes and stores each one into a fixed-size region of memory. It works the way a single DMA channel does. Software first programs a transfer length. It then starts the engine in one of two modes, circular or one-shot. After that, every byte that arrives while the engine runs appears as one write on the memory port.

A remaining-count output falls by one with every stored byte. Software reads it to locate the write position: the index equals the length minus the remaining count. In circular mode the count reloads to the length when it would reach zero, so the engine runs without end. Bytes the consumer has not yet read are simply overwritten on the next pass. In one-shot mode the count stops at zero and the engine goes idle.

Two single-cycle event pulses mark progress through the buffer. The half event marks the write of byte number floor(length/2). The complete event marks the write of the last slot. Both recur on every pass in circular mode.

Top module: `circ_rx_writer`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `remaining`=0, and `mem_we`, `ev_half` and `ev_full` are 0.
- R2: A `len_we` pulse while idle stores `len_in` as the transfer length. A `len_we` pulse while busy is ignored, so the next start still loads the earlier length.
- R3: A `start` pulse while idle with a nonzero stored length sets `busy`=1, loads `remaining` with the length, and latches `circ_mode` (1 = circular, 0 = one-shot). A start with a stored length of 0 leaves the engine idle.
- R4: Each byte with `in_valid`=1 while busy produces, one cycle later, `mem_we`=1 with `mem_wdata` equal to the byte. In the same cycle `mem_addr` equals the length minus the remaining count held before that byte, and `remaining` has decreased by one.
- R5: `ev_half` is high for exactly the cycle of the write that brings the pass count to floor(length/2). It never fires when that number is 0.
- R6: `ev_full` is high for exactly the cycle of the write to slot length-1. `ev_half` and `ev_full` are never high together.
- R7: In circular mode, after the last slot `remaining` reloads to the length instead of 0. Writes then continue at slot 0, overwriting older contents, and both events recur on every pass.
- R8: In one-shot mode, after the last slot `remaining`=0 and `busy`=0. Further bytes produce no write.
- R9: Bytes offered while idle produce no write and leave `remaining` unchanged.
- R10: A `stop` pulse clears `busy` and takes priority over a byte and over `start` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_we | input | 1 | Store `len_in` as transfer length (idle only) |
| len_in | input | LEN_W | Transfer length value |
| start | input | 1 | Begin a transfer |
| stop | input | 1 | Abort a transfer |
| circ_in | input | 1 | Mode for the next start: 1 circular, 0 one-shot |
| in_valid | input | 1 | Received byte present |
| in_data | input | DATA_W | Received byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write slot |
| mem_wdata | output | DATA_W | Memory write data |
| remaining | output | LEN_W | Bytes left in the current pass |
| busy | output | 1 | Transfer running |
| ev_half | output | 1 | Half-pass event pulse |
| ev_full | output | 1 | Full-pass event pulse |

## Verification
A byte, start or stop sampled at a rising edge shows its result right after that edge. The memory write, the event pulses, the new remaining count and the busy flag all appear together in the following cycle, with no further delay. The bench changes inputs on the falling edge and reads every result on the next falling edge, so each check lands exactly one cycle after its stimulus. The expected slot, count and event for byte k of a pass are computed from k modulo the length. Overwrite contents are checked after two idle cycles, through a memory model fed only by the write port.

// File: rtl/crw_pkg.sv
package crw_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_CIRC    = 1'b1
  } crw_mode_e;
endpackage

// File: rtl/crw_ctrl.sv
module crw_ctrl
  import crw_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_in,
  input  logic             start,
  input  logic             stop,
  input  logic             circ_in,
  input  logic             last_byte,
  output logic [LEN_W-1:0] len_q,
  output logic             active,
  output crw_mode_e        mode,
  output logic             load,
  output logic             run
);
  assign load = start && !stop && !active && (len_q != '0);
  assign run  = active && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      active <= 1'b0;
      mode   <= MODE_ONESHOT;
    end else begin
      if (len_we && !active) len_q <= len_in;
      if (stop) active <= 1'b0;
      else if (load) begin
        active <= 1'b1;
        mode   <= crw_mode_e'(circ_in);
      end else if (last_byte && mode == MODE_ONESHOT) active <= 1'b0;
    end
  end

  // R2: length register frozen while a transfer runs
  p_len_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active) |-> $stable(len_q));
  // R3: a start never takes hold with a zero length
  p_no_zero_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (len_q != '0));
endmodule

// File: rtl/crw_count.sv
module crw_count
  import crw_pkg::*;
#(
  parameter int LEN_W  = 6,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic              in_valid,
  input  logic [LEN_W-1:0]  len_q,
  input  crw_mode_e         mode,
  output logic [LEN_W-1:0]  rem_q,
  output logic              fire,
  output logic [ADDR_W-1:0] idx,
  output logic              last_byte,
  output logic              half_hit
);
  function automatic logic [ADDR_W-1:0] slot_of(input logic [LEN_W-1:0] len,
                                                input logic [LEN_W-1:0] rem);
    logic [LEN_W-1:0] diff;
    diff = len - rem;
    return diff[ADDR_W-1:0];
  endfunction

  function automatic logic [LEN_W-1:0] half_mark(input logic [LEN_W-1:0] len);
    return len - (len >> 1);
  endfunction

  assign fire      = run && in_valid;
  assign idx       = slot_of(len_q, rem_q);
  assign last_byte = fire && (rem_q == LEN_W'(1));
  assign half_hit  = fire && ((len_q >> 1) != '0) &&
                     ((rem_q - LEN_W'(1)) == half_mark(len_q));

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= '0;
    else if (load) rem_q <= len_q;
    else if (fire) begin
      if (rem_q == LEN_W'(1)) rem_q <= (mode == MODE_CIRC) ? len_q : '0;
      else rem_q <= rem_q - LEN_W'(1);
    end
  end

  // R4: remaining never exceeds the programmed length while running
  p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem_q <= len_q));
  // R7: circular mode never parks at zero
  p_circ_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == MODE_CIRC) |-> (rem_q != '0));
endmodule

// File: rtl/crw_port.sv
module crw_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] data,
  input  logic              half_hit,
  input  logic              last_byte,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ev_half,
  output logic              ev_full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ev_half   <= 1'b0;
      ev_full   <= 1'b0;
    end else begin
      mem_we  <= fire;
      ev_half <= half_hit;
      ev_full <= last_byte;
      if (fire) begin
        mem_addr  <= idx;
        mem_wdata <= data;
      end
    end
  end

  // R6: the two events are exclusive
  p_events_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_half, ev_full}));
  // R5: an event always rides on a write
  p_event_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_half || ev_full) |-> mem_we);
endmodule

// File: rtl/circ_rx_writer.sv
module circ_rx_writer
  import crw_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              start,
  input  logic              stop,
  input  logic              circ_in,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LEN_W-1:0]  remaining,
  output logic              busy,
  output logic              ev_half,
  output logic              ev_full
);
  logic [LEN_W-1:0]  len_q;
  crw_mode_e         mode;
  logic              load, run, fire, last_byte, half_hit;
  logic [ADDR_W-1:0] idx;

  crw_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_in(len_in),
    .start(start), .stop(stop), .circ_in(circ_in), .last_byte(last_byte),
    .len_q(len_q), .active(busy), .mode(mode), .load(load), .run(run)
  );

  crw_count #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run), .in_valid(in_valid),
    .len_q(len_q), .mode(mode), .rem_q(remaining), .fire(fire), .idx(idx),
    .last_byte(last_byte), .half_hit(half_hit)
  );

  crw_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .fire(fire), .idx(idx), .data(in_data),
    .half_hit(half_hit), .last_byte(last_byte), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ev_half(ev_half),
    .ev_full(ev_full)
  );

  // R6: completion writes the final slot
  p_full_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full |-> (LEN_W'(mem_addr) == len_q - LEN_W'(1)));
  // R5: half event writes slot floor(len/2)-1
  p_half_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_half |-> (LEN_W'(mem_addr) == (len_q >> 1) - LEN_W'(1)));
  // R8: one-shot completion leaves the engine idle
  p_oneshot_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_full && mode == MODE_ONESHOT) |-> (!busy && remaining == '0));
  // R9: no write unless the engine was running
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> !mem_we);
endmodule

// File: tb/sim_circ_rx_writer.sv
module sim_circ_rx_writer;
  localparam int MAXL = 32;
  localparam int DW   = 8;
  localparam int AW   = 5;
  localparam int LW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic len_we = 1'b0, start = 1'b0, stop = 1'b0, circ_in = 1'b0, in_valid = 1'b0;
  logic [LW-1:0] len_in = '0;
  logic [DW-1:0] in_data = '0;
  logic mem_we, busy, ev_half, ev_full;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [LW-1:0] remaining;
  logic [DW-1:0] model [MAXL];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  circ_rx_writer #(.MAX_LEN(MAXL), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_in(len_in), .start(start),
    .stop(stop), .circ_in(circ_in), .in_valid(in_valid), .in_data(in_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .remaining(remaining), .busy(busy), .ev_half(ev_half), .ev_full(ev_full)
  );

  always @(posedge clk) if (mem_we) model[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_len(input int n);
    @(negedge clk); len_we = 1'b1; len_in = LW'(n);
    @(negedge clk); len_we = 1'b0;
  endtask

  task automatic go(input bit c);
    @(negedge clk); start = 1'b1; circ_in = c;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic halt();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 37 + 11);
  endfunction

  // one byte, checked one cycle after the edge that takes it
  task automatic send(input int i, input bit exp_we, input int exp_addr,
                      input int exp_rem, input bit exp_h, input bit exp_f);
    @(negedge clk); in_valid = 1'b1; in_data = pat(i);
    @(negedge clk); in_valid = 1'b0;
    chk(mem_we == exp_we, "R4 we", int'(mem_we), int'(exp_we));
    if (exp_we) begin
      chk(int'(mem_addr) == exp_addr, "R4 addr", int'(mem_addr), exp_addr);
      chk(mem_wdata == pat(i), "R4 data", int'(mem_wdata), int'(pat(i)));
    end
    chk(int'(remaining) == exp_rem, "R4 remaining", int'(remaining), exp_rem);
    chk(ev_half == exp_h, "R5 half", int'(ev_half), int'(exp_h));
    chk(ev_full == exp_f, "R6 full", int'(ev_full), int'(exp_f));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && remaining == '0 && !mem_we && !ev_half && !ev_full,
        "R1 reset", int'(busy), 0);

    // R3 start with zero length ignored; R9 idle bytes ignored
    go(1'b1);
    chk(!busy, "R3 zero length start", int'(busy), 0);
    send(0, 1'b0, 0, 0, 1'b0, 1'b0);

    // R7 circular sweep over lengths, two passes and a bit
    for (int len = 2; len <= 9; len++) begin
      set_len(len);
      go(1'b1);
      chk(busy && int'(remaining) == len, "R3 load", int'(remaining), len);
      for (int k = 1; k <= 2 * len + 1; k++) begin
        int m;
        m = k % len;
        send(k, 1'b1, (k - 1) % len, (m == 0) ? len : len - m,
             (len / 2 > 0) && (m == len / 2), m == 0);
      end
      chk(busy, "R7 still running", int'(busy), 1);
      halt();
      chk(!busy, "R10 stop", int'(busy), 0);
      send(99, 1'b0, 0, len - 1, 1'b0, 1'b0);
    end

    // R8 one-shot sweep
    for (int len = 1; len <= 9; len++) begin
      set_len(len);
      go(1'b0);
      for (int k = 1; k <= len; k++)
        send(k, 1'b1, k - 1, len - k, (len / 2 > 0) && (k == len / 2), k == len);
      chk(!busy && remaining == '0, "R8 idle after last", int'(busy), 0);
      send(77, 1'b0, 0, 0, 1'b0, 1'b0);
      send(78, 1'b0, 0, 0, 1'b0, 1'b0);
    end

    // R2 length write while busy ignored
    set_len(5);
    go(1'b1);
    set_len(9);
    halt();
    go(1'b1);
    chk(int'(remaining) == 5, "R2 busy length write", int'(remaining), 5);
    halt();
    set_len(7);
    go(1'b0);
    chk(int'(remaining) == 7, "R2 idle length write", int'(remaining), 7);
    halt();

    // R10 stop beats a byte in the same cycle
    go(1'b1);
    @(negedge clk); stop = 1'b1; in_valid = 1'b1; in_data = 8'h5A;
    @(negedge clk); stop = 1'b0; in_valid = 1'b0;
    chk(!mem_we && !busy, "R10 stop priority", int'(mem_we), 0);

    // R7 overwrite: 30 bytes into a 20-slot ring
    set_len(20);
    go(1'b1);
    for (int k = 1; k <= 30; k++) begin
      int m;
      m = k % 20;
      send(100 + k, 1'b1, (k - 1) % 20, (m == 0) ? 20 : 20 - m, m == 10, m == 0);
    end
    repeat (2) @(negedge clk);
    for (int s = 0; s < 20; s++) begin
      int src;
      src = (s < 10) ? 100 + 21 + s : 100 + 1 + s;
      chk(model[s] == pat(src), "R7 overwrite", int'(model[s]), int'(pat(src)));
    end
    halt();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule